// File: doc/BRIEF.md
# Four-Tap Fixed-Coefficient FIR Filter with Valid Tracking

This block filters a stream of small unsigned samples with a four-tap finite impulse response. The weights are fixed: the newest sample is weighted by 1. The three samples accepted before it are weighted by 3, 2 and 1, from newest to oldest. Each sample arrives with a strobe. Only strobed samples enter the three-register delay line. On cycles without a strobe the line keeps its contents.

A valid bit moves through the delay line next to each sample. The output sum is registered. The output flag is raised only when the current sample and all three delayed taps hold real data accepted since the last reset. As a result, the partial sums that appear while the line fills are never marked as results. A downstream consumer takes `out_sum` only on cycles where `out_valid` is high.

Top module: `fir4_valid`

## Requirements
- R1: On an accepted sample x[n] (in_valid high), the next out_sum equals 1*x[n] + 3*x[n-1] + 2*x[n-2] + 1*x[n-3]. Here x[n-k] is the k-th earlier accepted sample, and a tap that has not been filled since reset counts as 0.
- R2: out_sum and out_valid are registered: they change only at the clock edge that captures the sample, and are visible in the cycle after it.
- R3: While the synchronous active-high rst is high at a clock edge, out_sum becomes 0, out_valid becomes 0, and every delay-line sample and valid bit becomes 0.
- R4: out_valid is 1 in a cycle only if the previous cycle had in_valid high and at least three earlier samples had been accepted since reset. The fourth accepted sample after reset is therefore the first one flagged.
- R5: When in_valid is low at a clock edge, the delay line does not shift, out_sum keeps its value and out_valid is 0.
- R6: A constant input of 1 settles to out_sum = 7 once out_valid is high.
- R7: A constant input of 15 (full scale) gives out_sum = 105, zero-extended in the 10-bit output with no overflow.
- R8: A reset in the middle of a stream clears the fill state. Four new accepted samples are needed before out_valid rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking in_sample as a real sample |
| in_sample | input | 4 | Unsigned input sample |
| out_valid | output | 1 | High when out_sum is a complete filter result |
| out_sum | output | 10 | Registered weighted sum, zero-extended |

## Verification
The bench builds the block with its default parameters: 4-bit samples and a 10-bit sum. With these values the full-scale input of 15 and its result of 105 can be reached directly, and the four-sample fill can be walked through one sample at a time. A reference model in the bench keeps its own sample history. The bench drives strobe gaps to show that the delay line holds, applies a reset mid-stream to show that the fill count restarts, and uses ramp and constant patterns to tell each tap weight apart.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int SAMPLE_W = 4;
  localparam int COEF_W   = 4;
  localparam int TAPS     = 4;
  localparam int PROD_W   = SAMPLE_W + COEF_W;
  localparam int SUM_W    = 10;

  // Fixed tap weights: index 0 is the newest sample.
  function automatic int tap_weight(input int idx);
    case (idx)
      0: return 1;
      1: return 3;
      2: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int weight_total(input int n);
    int t;
    t = 0;
    for (int i = 0; i < n; i++) t += tap_weight(i);
    return t;
  endfunction
endpackage

// File: rtl/fir4_delay_line.sv
module fir4_delay_line #(
  parameter int SAMPLE_W = fir4_pkg::SAMPLE_W,
  parameter int TAPS     = fir4_pkg::TAPS
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               shift_en,
  input  logic [SAMPLE_W-1:0]                din,
  output logic [TAPS-1:0][SAMPLE_W-1:0]      taps,
  output logic [TAPS-1:0]                    tap_vld
);
  localparam int STAGES = TAPS - 1;

  logic [STAGES-1:0][SAMPLE_W-1:0] stage_q;
  logic [STAGES-1:0]               vld_q;

  assign taps[0]    = din;
  assign tap_vld[0] = shift_en;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [SAMPLE_W-1:0] src_d;
      logic                src_v;
      if (g == 0) begin : g_head
        assign src_d = din;
        assign src_v = shift_en;
      end else begin : g_body
        assign src_d = stage_q[g-1];
        assign src_v = vld_q[g-1];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[g] <= '0;
          vld_q[g]   <= 1'b0;
        end else if (shift_en) begin
          stage_q[g] <= src_d;
          vld_q[g]   <= src_v;
        end
      end

      assign taps[g+1]    = stage_q[g];
      assign tap_vld[g+1] = vld_q[g];
    end
  endgenerate
endmodule

// File: rtl/fir4_tap_sum.sv
module fir4_tap_sum #(
  parameter int SAMPLE_W = fir4_pkg::SAMPLE_W,
  parameter int COEF_W   = fir4_pkg::COEF_W,
  parameter int TAPS     = fir4_pkg::TAPS,
  parameter int SUM_W    = fir4_pkg::SUM_W
) (
  input  logic [TAPS-1:0][SAMPLE_W-1:0] taps,
  output logic [SUM_W-1:0]              sum
);
  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic [TAPS-1:0][PROD_W-1:0] prod;

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_mul
      localparam logic [COEF_W-1:0] W = COEF_W'(fir4_pkg::tap_weight(g));
      assign prod[g] = PROD_W'(taps[g]) * PROD_W'(W);
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + SUM_W'(prod[i]);
  end
endmodule

// File: rtl/fir4_valid.sv
module fir4_valid #(
  parameter int SAMPLE_W = fir4_pkg::SAMPLE_W,
  parameter int COEF_W   = fir4_pkg::COEF_W,
  parameter int TAPS     = fir4_pkg::TAPS,
  parameter int SUM_W    = fir4_pkg::SUM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [SUM_W-1:0]    out_sum
);
  logic [TAPS-1:0][SAMPLE_W-1:0] taps;
  logic [TAPS-1:0]               tap_vld;
  logic [SUM_W-1:0]              sum_d;

  fir4_delay_line #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_line (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .din      (in_sample),
    .taps     (taps),
    .tap_vld  (tap_vld)
  );

  fir4_tap_sum #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS), .SUM_W(SUM_W)) u_sum (
    .taps (taps),
    .sum  (sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sum   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= &tap_vld;
      if (in_valid) out_sum <= sum_d;
    end
  end
endmodule

// File: rtl/fir4_valid_checker.sv
module fir4_valid_checker #(
  parameter int SAMPLE_W = fir4_pkg::SAMPLE_W,
  parameter int TAPS     = fir4_pkg::TAPS,
  parameter int SUM_W    = fir4_pkg::SUM_W
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                out_valid,
  input logic [SUM_W-1:0]    out_sum
);
  localparam int MAX_SUM = ((1 << SAMPLE_W) - 1) * fir4_pkg::weight_total(TAPS);
  localparam int CNT_W   = $clog2(TAPS + 1);

  logic [CNT_W-1:0] accepted;

  always_ff @(posedge clk) begin
    if (rst) accepted <= '0;
    else if (in_valid && accepted < CNT_W'(TAPS)) accepted <= accepted + 1'b1;
  end

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sum == '0));

  assert_valid_needs_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_valid_needs_fill_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (accepted >= CNT_W'(TAPS)));

  assert_hold_on_gap_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sum) && !out_valid));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum <= SUM_W'(MAX_SUM)));
endmodule

bind fir4_valid fir4_valid_checker #(
  .SAMPLE_W(SAMPLE_W), .TAPS(TAPS), .SUM_W(SUM_W)
) u_fir4_valid_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .out_valid (out_valid),
  .out_sum   (out_sum)
);

// File: tb/fir4_valid_test.sv
module fir4_valid_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_sample = '0;
  logic       out_valid;
  logic [9:0] out_sum;

  typedef struct {
    logic       v;
    logic [9:0] y;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   misses  = 0;
  int   hist0 = 0, hist1 = 0, hist2 = 0;
  int   filled = 0;
  int   last_y = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir4_valid uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_sample (in_sample),
    .out_valid (out_valid), .out_sum (out_sum)
  );

  task automatic drive(input bit r, input bit v, input int x, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; in_valid = v; in_sample = 4'(x);
    e.tag = tag;
    if (r) begin
      hist0 = 0; hist1 = 0; hist2 = 0; filled = 0; last_y = 0;
      e.v = 1'b0; e.y = '0;
    end else if (v) begin
      last_y = x + 3*hist0 + 2*hist1 + hist2;
      e.v = (filled >= 3);
      e.y = 10'(last_y);
      hist2 = hist1; hist1 = hist0; hist0 = x;
      filled++;
    end else begin
      e.v = 1'b0; e.y = 10'(last_y);
    end
    exp_q.push_back(e);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        vectors++;
        if (out_valid !== e.v || out_sum !== e.y) begin
          misses++;
          $display("FAIL %s: out_valid=%0b out_sum=%0d, expected out_valid=%0b out_sum=%0d",
                   e.tag, out_valid, out_sum, e.v, e.y);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R3: reset state
    drive(1, 0, 0, "R3");
    drive(1, 1, 9, "R3");
    // R4/R1/R2: fill with a ramp, flagged from the fourth sample
    drive(0, 1, 1, "R4");
    drive(0, 1, 2, "R4");
    drive(0, 1, 3, "R4");
    drive(0, 1, 4, "R1");
    drive(0, 1, 5, "R1");
    drive(0, 1, 6, "R2");
    // R5: gaps hold the line and the sum
    drive(0, 0, 15, "R5");
    drive(0, 0, 7, "R5");
    drive(0, 1, 0, "R5");
    // impulse shows each weight
    drive(0, 1, 8, "R1");
    drive(0, 1, 0, "R1");
    drive(0, 0, 3, "R5");
    drive(0, 1, 0, "R1");
    drive(0, 1, 0, "R1");
    drive(0, 1, 0, "R1");
    // R6: constant 1 settles to 7
    for (int i = 0; i < 6; i++) drive(0, 1, 1, "R6");
    // R7: full scale settles to 105
    for (int i = 0; i < 6; i++) drive(0, 1, 15, "R7");
    // R8: reset mid-stream restarts the fill
    drive(1, 1, 15, "R8");
    drive(0, 1, 15, "R8");
    drive(0, 1, 15, "R8");
    drive(0, 0, 2, "R8");
    drive(0, 1, 15, "R8");
    drive(0, 1, 15, "R8");
    drive(0, 1, 15, "R8");
    // alternating strobe pattern
    for (int i = 0; i < 10; i++) drive(0, i % 2, i, "R5");
    drive(0, 0, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule